// File: doc/BRIEF.md
# Two-Operand ALU with Status Flags

This block is a combinational integer ALU with a small registered status word. It takes two operands, a left operand and a right operand, and each one passes through its own two's-complement negation stage before both reach a shared operation section. Subtraction is done as the left operand plus the negated right operand. The negate-then-add operation negates the left operand instead. The operation section also provides bitwise AND, OR and XOR and an unsigned integer divide.

Addition uses a ripple chain. Bit zero is a half adder. Every higher bit is a full adder made of two half adders whose carries are ORed together. Each negation stage inverts its operand and adds one through a chain of half adders. The width is a parameter, so a wider ALU only adds stages to these chains.

Three status flags record unusual outcomes: overflow, divide-by-zero and sign change. They are loaded on a rising clock edge when the update enable is high and are cleared by a synchronous reset. The result output is purely combinational.

Top module: `alu_flags`

## Requirements
- R1: Opcode 3'b000 (add) drives `res` with `lhs + rhs` modulo 2^W in the same cycle.
- R2: Opcode 3'b001 (subtract) drives `res` with `lhs - rhs` modulo 2^W, formed as `lhs` plus the two's complement of `rhs`.
- R3: Opcode 3'b010 (negate-then-add) drives `res` with `rhs - lhs` modulo 2^W, formed as the two's complement of `lhs` plus `rhs`.
- R4: Opcodes 3'b011, 3'b100 and 3'b101 drive `res` with the bitwise AND, OR and XOR of the operands.
- R5: Opcode 3'b110 (divide) with a nonzero `rhs` drives `res` with the unsigned quotient floor(`lhs`/`rhs`).
- R6: A divide with `rhs` equal to zero drives `res` to all zeros. After an enabled update it leaves `f_dz`=1, `f_ovf`=0 and `f_sgn`=0.
- R7: After an enabled update, `f_ovf` is 1 exactly when the opcode is add, subtract or negate-then-add and the two adder inputs (after any negation) share a sign that differs from the sign of the sum. For every other opcode it is 0.
- R8: After an enabled update for anything other than a divide by zero, `f_sgn` is 1 exactly when bit W-1 of `res` differs from bit W-1 of `lhs`. `f_dz` is 0 in that case.
- R9: While `flag_en` is low, a clock edge leaves all three flags unchanged, whatever the opcode and operands.
- R10: With `rst` high, a clock edge clears all three flags, even when `flag_en` is high.
- R11: Opcode 3'b111 is reserved. It drives `res` to zero, and an enabled update with it gives `f_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high, clears the flags |
| op | input | 3 | Operation code |
| lhs | input | W | Left operand |
| rhs | input | W | Right operand |
| flag_en | input | 1 | Loads the flags on the next rising edge when high |
| res | output | W | Combinational result |
| f_ovf | output | 1 | Registered signed-overflow flag |
| f_dz | output | 1 | Registered divide-by-zero flag |
| f_sgn | output | 1 | Registered sign-change flag |

## Verification
The embedded assertions check several rules on every clock. The flags hold while the enable is low. A divide by zero gives a zero result and then leaves divide-by-zero set with the other two flags clear. Logic operations and operands of opposite sign in an add never raise overflow. The reserved opcode always yields zero. The exact arithmetic values can only be shown by the bench's directed scenarios, which compare against values worked out independently. This covers sums and differences that wrap, quotients, the carry-based overflow detection across sign combinations, and reset taking priority over an active enable.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         flag_en,
  output logic [W-1:0] res,
  output logic         f_ovf,
  output logic         f_dz,
  output logic         f_sgn
);
  localparam logic [2:0] OP_ADD  = 3'b000;
  localparam logic [2:0] OP_SUB  = 3'b001;
  localparam logic [2:0] OP_NADD = 3'b010;
  localparam logic [2:0] OP_AND  = 3'b011;
  localparam logic [2:0] OP_OR   = 3'b100;
  localparam logic [2:0] OP_XOR  = 3'b101;
  localparam logic [2:0] OP_DIV  = 3'b110;
  localparam int TOP = W - 1;

  logic         neg_l, neg_r, is_arith, div_zero;
  logic [W-1:0] inv_l, inv_r, nl_s, nr_s;
  logic [W-2:0] nl_c, nr_c;
  logic [W-1:0] ax, ay, sum, hp, hg, hg2, cy;
  logic [W-1:0] quo;
  logic [W:0]   rem;
  logic         ovf_n, dz_n, sgn_n;

  assign neg_l    = (op == OP_NADD);
  assign neg_r    = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || neg_l || neg_r;
  assign div_zero = (op == OP_DIV) && (rhs == '0);
  assign inv_l    = ~lhs;
  assign inv_r    = ~rhs;

  // two's-complement stages: invert, then a half-adder chain adds one
  for (genvar i = 0; i < W; i++) begin : g_neg
    if (i == 0) begin : g_lsb
      assign nl_s[0] = ~inv_l[0];
      assign nr_s[0] = ~inv_r[0];
      assign nl_c[0] = inv_l[0];
      assign nr_c[0] = inv_r[0];
    end else begin : g_up
      assign nl_s[i] = inv_l[i] ^ nl_c[i-1];
      assign nr_s[i] = inv_r[i] ^ nr_c[i-1];
      if (i < TOP) begin : g_carry
        assign nl_c[i] = inv_l[i] & nl_c[i-1];
        assign nr_c[i] = inv_r[i] & nr_c[i-1];
      end
    end
  end

  assign ax = neg_l ? nl_s : lhs;
  assign ay = neg_r ? nr_s : rhs;

  // ripple adder: half adder at bit 0, two half adders plus OR above
  for (genvar i = 0; i < W; i++) begin : g_add
    assign hp[i] = ax[i] ^ ay[i];
    assign hg[i] = ax[i] & ay[i];
    if (i == 0) begin : g_half
      assign sum[0] = hp[0];
      assign hg2[0] = 1'b0;
      assign cy[0]  = hg[0];
    end else begin : g_full
      assign sum[i] = hp[i] ^ cy[i-1];
      assign hg2[i] = hp[i] & cy[i-1];
      assign cy[i]  = hg[i] | hg2[i];
    end
  end

  // restoring unsigned divider
  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = W - 1; i >= 0; i--) begin
      rem = {rem[W-1:0], lhs[i]};
      if (rem >= {1'b0, rhs}) begin
        rem    = rem - {1'b0, rhs};
        quo[i] = 1'b1;
      end
    end
  end

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB, OP_NADD: res = sum;
      OP_AND:                  res = lhs & rhs;
      OP_OR:                   res = lhs | rhs;
      OP_XOR:                  res = lhs ^ rhs;
      OP_DIV:                  res = div_zero ? '0 : quo;
      default:                 res = '0;
    endcase
  end

  assign ovf_n = is_arith & (cy[TOP] ^ cy[TOP-1]);
  assign dz_n  = div_zero;
  assign sgn_n = ~div_zero & (res[TOP] ^ lhs[TOP]);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_ovf <= 1'b0;
      f_dz  <= 1'b0;
      f_sgn <= 1'b0;
    end else if (flag_en) begin
      f_ovf <= ovf_n;
      f_dz  <= dz_n;
      f_sgn <= sgn_n;
    end
  end

  assert_div_zero_result_R6: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && rhs == '0) |-> (res == '0));

  assert_div_zero_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op == OP_DIV && rhs == '0) |=> (f_dz && !f_ovf && !f_sgn));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_en && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_DIV)) |=> !f_ovf);

  assert_mixed_sign_add_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_en && op == OP_ADD && lhs[TOP] != rhs[TOP]) |=> !f_ovf);

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !flag_en |=> ($stable(f_ovf) && $stable(f_dz) && $stable(f_sgn)));

  assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (op == 3'b111) |-> (res == '0));
endmodule

// File: tb/alu_flags_tb_top.sv
module alu_flags_tb_top;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst, flag_en;
  logic [2:0] op;
  logic [W-1:0] lhs, rhs, res;
  logic f_ovf, f_dz, f_sgn;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  alu_flags #(.W(W)) dut_i (.clk(clk), .rst(rst), .op(op), .lhs(lhs), .rhs(rhs),
    .flag_en(flag_en), .res(res), .f_ovf(f_ovf), .f_dz(f_dz), .f_sgn(f_sgn));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
      output logic [W-1:0] r, output logic v, output logic z, output logic s);
    logic [W-1:0] x, y, t;
    x = (o == 3'b010) ? -a : a;
    y = (o == 3'b001) ? -b : b;
    t = x + y;
    z = 1'b0;
    case (o)
      3'b000: r = a + b;
      3'b001: r = a - b;
      3'b010: r = b - a;
      3'b011: r = a & b;
      3'b100: r = a | b;
      3'b101: r = a ^ b;
      3'b110: begin
        z = (b == 0);
        r = z ? '0 : a / b;
      end
      default: r = '0;
    endcase
    v = (o <= 3'b010) && (x[W-1] == y[W-1]) && (t[W-1] != x[W-1]);
    s = !z && (r[W-1] != a[W-1]);
  endfunction

  task automatic run_op(input string tag, input logic [2:0] o, input logic [W-1:0] a,
      input logic [W-1:0] b);
    logic [W-1:0] er;
    logic ev, ez, es;
    model(o, a, b, er, ev, ez, es);
    @(negedge clk);
    op = o; lhs = a; rhs = b; flag_en = 1'b1;
    #1 chk({tag, " res"}, res, er);
    @(negedge clk);
    chk({tag, " f_ovf R7"}, {7'b0, f_ovf}, {7'b0, ev});
    chk({tag, " f_dz R6"}, {7'b0, f_dz}, {7'b0, ez});
    chk({tag, " f_sgn R8"}, {7'b0, f_sgn}, {7'b0, es});
    flag_en = 1'b0;
  endtask

  task automatic t_reset_R10();
    run_op("R7 ovf setup", 3'b000, 8'h70, 8'h70);
    @(negedge clk);
    rst = 1'b1; flag_en = 1'b1; op = 3'b000; lhs = 8'h70; rhs = 8'h70;
    @(negedge clk);
    chk("R10 f_ovf", {7'b0, f_ovf}, 8'h0);
    chk("R10 f_sgn", {7'b0, f_sgn}, 8'h0);
    chk("R10 f_dz", {7'b0, f_dz}, 8'h0);
    rst = 1'b0; flag_en = 1'b0;
  endtask

  task automatic t_add_R1();
    run_op("R1 add small", 3'b000, 8'h12, 8'h34);
    run_op("R1 add wrap", 3'b000, 8'hF0, 8'h20);
    run_op("R1 add ovf pos", 3'b000, 8'h7F, 8'h01);
    run_op("R1 add ovf neg", 3'b000, 8'h80, 8'hFF);
    run_op("R1 add mixed", 3'b000, 8'h80, 8'h7F);
  endtask

  task automatic t_sub_R2();
    run_op("R2 sub", 3'b001, 8'h50, 8'h20);
    run_op("R2 sub borrow", 3'b001, 8'h10, 8'h20);
    run_op("R2 sub ovf", 3'b001, 8'h80, 8'h01);
    run_op("R2 sub ovf2", 3'b001, 8'h7F, 8'hFF);
  endtask

  task automatic t_nadd_R3();
    run_op("R3 nadd", 3'b010, 8'h05, 8'h03);
    run_op("R3 nadd pos", 3'b010, 8'h03, 8'h09);
    run_op("R3 nadd ovf", 3'b010, 8'h01, 8'h80);
  endtask

  task automatic t_logic_R4();
    run_op("R4 and", 3'b011, 8'hCA, 8'h5F);
    run_op("R4 or", 3'b100, 8'h0A, 8'hA0);
    run_op("R4 xor", 3'b101, 8'hFF, 8'h81);
  endtask

  task automatic t_div_R5();
    run_op("R5 div", 3'b110, 8'd200, 8'd7);
    run_op("R5 div exact", 3'b110, 8'd255, 8'd15);
    run_op("R5 div by one", 3'b110, 8'h9C, 8'd1);
    run_op("R5 div small", 3'b110, 8'd3, 8'd9);
  endtask

  task automatic t_divzero_R6();
    run_op("R1 prime sgn", 3'b000, 8'h7F, 8'h01);
    run_op("R6 divzero", 3'b110, 8'hFF, 8'h00);
    run_op("R6 divzero0", 3'b110, 8'h00, 8'h00);
  endtask

  task automatic t_hold_R9();
    run_op("R7 setup hold", 3'b000, 8'h7F, 8'h01);
    @(negedge clk);
    flag_en = 1'b0; op = 3'b110; lhs = 8'h01; rhs = 8'h00;
    @(negedge clk);
    op = 3'b011; lhs = 8'h00; rhs = 8'h00;
    @(negedge clk);
    chk("R9 f_ovf held", {7'b0, f_ovf}, 8'h1);
    chk("R9 f_sgn held", {7'b0, f_sgn}, 8'h1);
    chk("R9 f_dz held", {7'b0, f_dz}, 8'h0);
  endtask

  task automatic t_reserved_R11();
    run_op("R11 reserved", 3'b111, 8'hAB, 8'hCD);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 6; j++) begin
        run_op("R8 sweep", 3'(j), 8'(i * 37 + 11), 8'(i * 53 + 100));
      end
    end
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; flag_en = 1'b0; op = 3'b000; lhs = '0; rhs = '0;
    repeat (3) @(negedge clk);
    chk("R10 reset ovf", {7'b0, f_ovf}, 8'h0);
    chk("R10 reset dz", {7'b0, f_dz}, 8'h0);
    chk("R10 reset sgn", {7'b0, f_sgn}, 8'h0);
    rst = 1'b0;
    t_add_R1();
    t_sub_R2();
    t_nadd_R3();
    t_logic_R4();
    t_div_R5();
    t_divzero_R6();
    t_hold_R9();
    t_reserved_R11();
    t_reset_R10();
    t_sweep();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule